// File: doc/BRIEF.md
# Configurable UART Serial Transmitter

This block takes bytes from a show-ahead transmit FIFO and sends them out one frame at a time on a single serial line. The line rests high. A frame opens with a low start bit. The eight data bits follow, least significant bit first. An optional parity bit comes next, and the frame closes with one or two high stop bits. Parity and stop-bit count can be changed at run time. The values in force when a byte is taken from the FIFO apply to that whole frame.

Bit timing comes from a free-running divider. The divider produces a baud tick once every `divisor + 1` clock cycles, which is sixteen times the bit rate. Every serial bit therefore lasts sixteen ticks. A frame can begin only on a tick. It begins when transmission is enabled, the FIFO holds data, and the line is idle or the last stop bit is just ending. Frames can therefore run back to back with no idle gap.

Top module: `uart_tx`

## Requirements
- R1: After reset the serial line is high, no FIFO read is issued, and the divider count is zero, so the first baud tick comes `baud_div_i` cycles after reset is released.
- R2: A baud tick happens every `baud_div_i + 1` clock cycles, and every serial bit is held for exactly 16 ticks. The line changes in the cycle after the tick that ends a bit.
- R3: A frame starts with one low start bit. The eight data bits follow, bit 0 first.
- R4: With `par_mode_i` = 1 (even), a parity bit follows the data so that the data and parity together hold an even number of ones.
- R5: With `par_mode_i` = 2 (odd), a parity bit follows the data so that the data and parity together hold an odd number of ones.
- R6: With `par_mode_i` = 0 or 3, no parity bit is sent and the stop bits follow the last data bit directly.
- R7: With `two_stop_i` = 0, the frame ends with one high stop bit. With `two_stop_i` = 1, it ends with two.
- R8: While `tx_en_i` is low, `fifo_pop_o` stays low. A frame already in progress when `tx_en_i` falls still runs to its end.
- R9: `fifo_pop_o` pulses for one cycle, only on a baud tick, only when `fifo_empty_i` is low, and only when the line is idle or the final stop bit ends on that tick. The popped byte's start bit follows with no gap.
- R10: Parity mode and stop count are captured with the byte. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable |
| par_mode_i | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 none |
| two_stop_i | input | 1 | 0: one stop bit, 1: two stop bits |
| baud_div_i | input | 12 | Divisor; tick period is value + 1 cycles |
| fifo_empty_i | input | 1 | FIFO has no data |
| fifo_data_i | input | 8 | Head byte of the FIFO (show-ahead) |
| fifo_pop_o | output | 1 | Read strobe to the FIFO |
| txd_o | output | 1 | Serial line, idles high |

## Verification
`fifo_pop_o` is combinational from the divider and the frame state. It is therefore due in the very cycle of the tick that allows a start. The serial line is registered and is due one cycle after the edge that ends a bit. The bench's reference model steps once per clock edge. It predicts both outputs from a queue of frame bits built from the popped byte and the captured settings. It compares them at the falling edge, half a cycle after the registers move. The FIFO head is advanced just after the edge that consumed it, so the byte the design captures is the one the model expects.

// File: rtl/uart_tx_pkg.sv
// Shared types for the serial transmitter.
// Assumes: parity mode encoding 0 none, 1 even, 2 odd, 3 none.
package uart_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    localparam logic [1:0] PAR_EVEN = 2'd1;
    localparam logic [1:0] PAR_ODD  = 2'd2;
endpackage

// File: rtl/uart_tx_baud.sv
// Baud divider: emits a one-cycle tick every (div_i + 1) cycles.
// Assumes: div_i may change at any time; a count above the new value wraps at once.
module uart_tx_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = (cnt_q >= div_i);

    // Advance the divider, clearing it on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    AST_TICK_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == '0)); // R2
    AST_CNT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_o |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
endmodule

// File: rtl/uart_tx_parity.sv
// Parity generator: decides from the mode whether a parity bit is sent and its value.
// Assumes: data is the byte about to be framed; modes 0 and 3 both mean no parity.
module uart_tx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [1:0]        mode_i,
    output logic              par_en_o,
    output logic              par_bit_o
);
    import uart_tx_pkg::*;

    // Map the mode to enable and polarity of the extra bit.
    always_comb begin
        par_en_o  = 1'b0;
        par_bit_o = 1'b0;
        case (mode_i)
            PAR_EVEN: begin par_en_o = 1'b1; par_bit_o = ^data_i;    end
            PAR_ODD:  begin par_en_o = 1'b1; par_bit_o = ~(^data_i); end
            default:  ;
        endcase
    end
endmodule

// File: rtl/uart_tx_frame.sv
// Frame sequencer: pops a byte on a tick, then shifts start, data, parity and stop
// bits, each held for OVERSAMPLE ticks. Settings are captured at the pop.
// Assumes: fifo_data_i is valid whenever fifo_empty_i is low (show-ahead FIFO).
module uart_tx_frame #(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic              fifo_empty_i,
    input  logic [DATA_W-1:0] fifo_data_i,
    input  logic              par_en_i,
    input  logic              par_bit_i,
    input  logic              two_stop_i,
    output logic              pop_o,
    output logic              txd_o
);
    import uart_tx_pkg::*;

    localparam int SUB_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    tx_state_e         state_q;
    logic [SUB_W-1:0]  sub_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              par_en_q, par_bit_q, two_stop_q, stop_sec_q;
    logic              txd_q;
    logic              bit_end, last_stop, launch;

    assign bit_end   = tick_i && (sub_q == SUB_LAST);
    assign last_stop = (state_q == ST_STOP) && (!two_stop_q || stop_sec_q);
    assign launch    = tick_i && en_i && !fifo_empty_i &&
                       ((state_q == ST_IDLE) || (bit_end && last_stop));
    assign pop_o     = launch;
    assign txd_o     = txd_q;

    // Load a new frame, or step the tick count and the bit sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            sub_q      <= '0;
            idx_q      <= '0;
            shreg_q    <= '0;
            par_en_q   <= 1'b0;
            par_bit_q  <= 1'b0;
            two_stop_q <= 1'b0;
            stop_sec_q <= 1'b0;
            txd_q      <= 1'b1;
        end else if (launch) begin
            state_q    <= ST_START;
            sub_q      <= '0;
            idx_q      <= '0;
            shreg_q    <= fifo_data_i;
            par_en_q   <= par_en_i;
            par_bit_q  <= par_bit_i;
            two_stop_q <= two_stop_i;
            stop_sec_q <= 1'b0;
            txd_q      <= 1'b0;
        end else if (tick_i && state_q != ST_IDLE) begin
            if (!bit_end) begin
                sub_q <= sub_q + 1'b1;
            end else begin
                sub_q <= '0;
                case (state_q)
                    ST_START: begin
                        state_q <= ST_DATA;
                        idx_q   <= '0;
                        txd_q   <= shreg_q[0];
                    end
                    ST_DATA: begin
                        if (idx_q == IDX_LAST) begin
                            state_q <= par_en_q ? ST_PARITY : ST_STOP;
                            txd_q   <= par_en_q ? par_bit_q : 1'b1;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            shreg_q <= shreg_q >> 1;
                            txd_q   <= shreg_q[1];
                        end
                    end
                    ST_PARITY: begin
                        state_q <= ST_STOP;
                        txd_q   <= 1'b1;
                    end
                    ST_STOP: begin
                        if (two_stop_q && !stop_sec_q) begin
                            stop_sec_q <= 1'b1;
                        end else begin
                            state_q <= ST_IDLE;
                            txd_q   <= 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> txd_q); // R1
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |=> (!txd_o && state_q == ST_START)); // R3
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> ($stable(txd_q) && $stable(sub_q))); // R2
    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |-> txd_q); // R7
endmodule

// File: rtl/uart_tx.sv
// Serial transmitter top: divider, parity generator and frame sequencer.
// Assumes: a show-ahead FIFO drives fifo_data_i/fifo_empty_i and pops on fifo_pop_o.
module uart_tx #(
    parameter int DIV_W      = 12,
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en_i,
    input  logic [1:0]        par_mode_i,
    input  logic              two_stop_i,
    input  logic [DIV_W-1:0]  baud_div_i,
    input  logic              fifo_empty_i,
    input  logic [DATA_W-1:0] fifo_data_i,
    output logic              fifo_pop_o,
    output logic              txd_o
);
    logic tick, par_en, par_bit;

    uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (baud_div_i),
        .tick_o (tick)
    );

    uart_tx_parity #(.DATA_W(DATA_W)) u_par (
        .data_i    (fifo_data_i),
        .mode_i    (par_mode_i),
        .par_en_o  (par_en),
        .par_bit_o (par_bit)
    );

    uart_tx_frame #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .en_i         (tx_en_i),
        .fifo_empty_i (fifo_empty_i),
        .fifo_data_i  (fifo_data_i),
        .par_en_i     (par_en),
        .par_bit_i    (par_bit),
        .two_stop_i   (two_stop_i),
        .pop_o        (fifo_pop_o),
        .txd_o        (txd_o)
    );

    AST_POP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |-> tx_en_i); // R8
    AST_POP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |-> tick); // R9
    AST_SINGLE_POP: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |=> !fifo_pop_o); // R9
endmodule

// File: tb/tb_uart_tx.sv
`timescale 1ns/1ps
module tb_uart_tx;
    localparam int DIV_W = 12;
    localparam int DATA_W = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              tx_en = 1'b0;
    logic [1:0]        par_mode = 2'd0;
    logic              two_stop = 1'b0;
    logic [DIV_W-1:0]  baud_div = 12'd2;
    logic              fifo_empty = 1'b1;
    logic [DATA_W-1:0] fifo_data = '0;
    logic              fifo_pop, txd;

    uart_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W), .OVERSAMPLE(16)) dut (
        .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .par_mode_i(par_mode),
        .two_stop_i(two_stop), .baud_div_i(baud_div), .fifo_empty_i(fifo_empty),
        .fifo_data_i(fifo_data), .fifo_pop_o(fifo_pop), .txd_o(txd)
    );

    int checks = 0, fails = 0;
    string phase_tag = "";
    logic [7:0] fq[$];
    bit pop_pending = 0, checking = 0;

    // Reference model state
    int    m_cnt = 0, m_sub = 0;
    bit    m_busy = 0, m_line = 1;
    string m_tag = "R1";
    bit    bitq[$];
    string tagq[$];

    function automatic void refresh();
        fifo_empty = (fq.size() == 0);
        fifo_data  = (fq.size() != 0) ? fq[0] : '0;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare outputs, then step the model as the coming edge will.
    always @(negedge clk) if (checking) begin
        bit tick, done_now, exp_pop;
        string t;
        tick     = (m_cnt >= int'(baud_div));
        done_now = m_busy && tick && m_sub == 15 && bitq.size() == 0;
        exp_pop  = tick && tx_en && !fifo_empty && (!m_busy || done_now);
        t = (phase_tag != "") ? phase_tag : m_tag;
        chk(txd == m_line, t, txd, m_line);
        t = (phase_tag != "") ? phase_tag : (tx_en ? "R9" : "R8");
        chk(fifo_pop == exp_pop, t, fifo_pop, exp_pop);
        m_cnt = tick ? 0 : m_cnt + 1;
        if (exp_pop) begin
            logic [7:0] d;
            d = fq[0];
            bitq.delete(); tagq.delete();
            for (int i = 0; i < 8; i++) begin bitq.push_back(d[i]); tagq.push_back("R3"); end
            if (par_mode == 2'd1) begin bitq.push_back(^d); tagq.push_back("R4"); end
            else if (par_mode == 2'd2) begin bitq.push_back(~(^d)); tagq.push_back("R5"); end
            bitq.push_back(1'b1);
            tagq.push_back((par_mode == 2'd0 || par_mode == 2'd3) ? "R6" : "R7");
            if (two_stop) begin bitq.push_back(1'b1); tagq.push_back("R7"); end
            m_busy = 1; m_sub = 0; m_line = 0; m_tag = "R3";
            pop_pending = 1;
        end else if (m_busy && tick) begin
            if (m_sub == 15) begin
                m_sub = 0;
                if (bitq.size() != 0) begin
                    m_line = bitq.pop_front(); m_tag = tagq.pop_front();
                end else begin
                    m_busy = 0; m_line = 1; m_tag = "R1";
                end
            end else m_sub++;
        end
    end

    // FIFO head advances just after the edge that consumed it.
    always @(posedge clk) begin
        #1;
        if (pop_pending) begin
            if (fq.size() != 0) void'(fq.pop_front());
            pop_pending = 0;
            refresh();
        end
    end

    task automatic push(logic [7:0] b);
        fq.push_back(b);
        refresh();
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 40000 && (fq.size() != 0 || m_busy || pop_pending); i++)
            @(posedge clk);
        #1;
        cyc(20);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9: watchdog expired, actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        checking = 1;
        @(negedge clk);
        chk(txd == 1'b1, "R1", txd, 1);
        chk(fifo_pop == 1'b0, "R1", fifo_pop, 0);
        cyc(10);
        // Enabled with an empty FIFO: nothing happens.
        tx_en = 1'b1;
        cyc(30);
        // R6: no parity, one stop
        par_mode = 2'd0; two_stop = 1'b0;
        push(8'hA5);
        wait_done();
        // R4: even parity, back-to-back bytes
        par_mode = 2'd1;
        push(8'h37); push(8'h00);
        wait_done();
        // R5 and R7: odd parity, two stops
        par_mode = 2'd2; two_stop = 1'b1;
        push(8'hFF); push(8'h81);
        wait_done();
        // R6: mode 3 behaves as none
        par_mode = 2'd3;
        push(8'h5A); push(8'h01);
        wait_done();
        // R8: disabled with data waiting, then dropped mid-frame
        tx_en = 1'b0; par_mode = 2'd1; two_stop = 1'b0;
        push(8'h3C); push(8'hC3);
        cyc(300);
        chk(fq.size() == 2, "R8", fq.size(), 2);
        tx_en = 1'b1;
        for (int i = 0; i < 100 && !m_busy; i++) cyc(1);
        cyc(100);
        tx_en = 1'b0;
        cyc(1500);
        chk(fq.size() == 1, "R8", fq.size(), 1);
        chk(txd == 1'b1, "R8", txd, 1);
        tx_en = 1'b1;
        wait_done();
        // R10: settings changed during a frame
        phase_tag = "R10";
        par_mode = 2'd2; two_stop = 1'b1;
        push(8'h96);
        for (int i = 0; i < 100 && !m_busy; i++) cyc(1);
        cyc(50);
        par_mode = 2'd0; two_stop = 1'b0;
        wait_done();
        // R2: other divisors, including one tick per cycle
        phase_tag = "R2";
        baud_div = 12'd0; par_mode = 2'd1;
        push(8'h6B);
        wait_done();
        baud_div = 12'd5; two_stop = 1'b1;
        push(8'hE4);
        wait_done();
        phase_tag = "";
        checking = 0;
        summary();
        $finish;
    end
endmodule